// File: doc/BRIEF.md
# Byte-Parity Cache Data Array

This block is the data half of a cache line store. Every byte written into it gets an even-parity bit computed alongside it and kept next to it. Every read re-derives the parity of the returned bytes and compares it with the stored bits. Only the bytes the requester asks for take part in the comparison. A mismatch does not hold back the read. The word is handed out with its valid flag as usual, a sticky error flag is set in a fault status word, and an abort pulse follows one cycle later. The abort is therefore imprecise: by the time it arrives, the corrupt word may already be in use.

Tags live in a separate array that has no parity and no check, so they are not part of this block. A test-only port flips a single stored data bit without touching its parity, which gives the error path a way to be exercised. Software clears the status flag through a dedicated clear input.

Top module: `pda_top`

## Requirements
- R1: A read request (`rd_en`) returns the stored word on `rd_data` with `rd_valid` high exactly one cycle later. A word written with all four byte enables reads back unchanged and raises no error.
- R2: On a write, only the bytes whose `wr_be` bit is set (bit b covers data bits 8b+7..8b) change, and only their parity is regenerated. The other bytes keep both their data and their parity.
- R3: The check covers only the bytes selected by `rd_be`. A corrupt byte outside that mask raises neither the status flag nor an abort.
- R4: A parity mismatch in any checked byte sets bit 10 of `fsr` two cycles after `rd_en`, which is one cycle after `rd_valid`. The parity stored per byte is even, meaning the XOR of the eight data bits.
- R5: An abort is signalled as a one-cycle pulse on `abort` three cycles after the faulty `rd_en`, one cycle after the status bit. Each faulty read gives exactly one pulse.
- R6: A read that fails the check still delivers its data, corrupt bits included, with `rd_valid` high.
- R7: Bit 10 of `fsr` stays set until `fsr_clr` is asserted. When a new error and a clear meet in the same cycle, the bit stays set. All other `fsr` bits are always zero.
- R8: `inj_en` inverts data bit `inj_bit` of line `inj_addr` and leaves its parity alone. A write to the same line in the same cycle wins and the flip is dropped. Rewriting a corrupted byte repairs it.
- R9: After reset, `rd_valid`, `abort` and `fsr` are zero, and every line reads as zero without any error.
- R10: A read and a write to the same line in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Line written |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables for the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Line read |
| rd_be | input | 4 | Bytes read and checked |
| rd_data | output | 32 | Read data |
| rd_valid | output | 1 | Read data valid |
| abort | output | 1 | Imprecise data-abort pulse |
| fsr | output | 16 | Fault status word, bit 10 = parity error |
| fsr_clr | input | 1 | Clears the parity error bit |
| inj_en | input | 1 | Test-only bit-flip strobe |
| inj_addr | input | 4 | Line whose bit is flipped |
| inj_bit | input | 5 | Data bit index to flip |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a new mismatch. The mismatch exists only during the single cycle in which the faulty word sits on the read output. To get there, the bench corrupts a line through the injection port, issues the read, and raises `fsr_clr` at the very next falling edge, while `rd_valid` is high. It then checks that the flag survived. It also puts a corrupt byte outside the read mask, and it lines up an injection with a write to the same line in one cycle.

// File: rtl/pda_pkg.sv
package pda_pkg;
  localparam int BYTE_W = 8;

  // even parity over one byte: stored bit makes the total count of ones even
  function automatic logic byte_par(input logic [BYTE_W-1:0] b);
    return ^b;
  endfunction

  // collapse a per-byte error vector to a single event
  function automatic logic any_err(input logic [15:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/pda_par_gen.sv
module pda_par_gen #(
  parameter int NBYTES = 4,
  localparam int DW = NBYTES * pda_pkg::BYTE_W
) (
  input  logic [DW-1:0]     data,
  output logic [NBYTES-1:0] par
);
  import pda_pkg::*;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign par[b] = byte_par(data[b*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/pda_store.sv
module pda_store #(
  parameter int NBYTES = 4,
  parameter int DEPTH  = 16,
  localparam int DW    = NBYTES * pda_pkg::BYTE_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [NBYTES-1:0] wr_par,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NBYTES-1:0] rd_be,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [BW-1:0]     inj_bit,
  output logic [DW-1:0]     rdata_q,
  output logic [NBYTES-1:0] rpar_q,
  output logic [NBYTES-1:0] rbe_q,
  output logic              rvalid_q
);
  import pda_pkg::*;

  logic [DW-1:0]     mem_q [DEPTH];
  logic [NBYTES-1:0] par_q [DEPTH];

  // named events for assertions
  logic inj_hit_wr;
  assign inj_hit_wr = inj_en && wr_en && (inj_addr == wr_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < DEPTH; l++) begin
        mem_q[l] <= '0;
        par_q[l] <= '0;
      end
    end else begin
      for (int l = 0; l < DEPTH; l++) begin
        if (wr_en && (wr_addr == AW'(l))) begin
          for (int b = 0; b < NBYTES; b++) begin
            if (wr_be[b]) begin
              mem_q[l][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
              par_q[l][b]                  <= wr_par[b];
            end
          end
        end else if (inj_en && (inj_addr == AW'(l))) begin
          mem_q[l][inj_bit] <= ~mem_q[l][inj_bit];
        end
      end
    end
  end

  // registered read, read-before-write on a shared line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rpar_q   <= '0;
      rbe_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        rdata_q <= mem_q[rd_addr];
        rpar_q  <= par_q[rd_addr];
        rbe_q   <= rd_be;
      end
    end
  end

  assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q);
  assert_inject_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_hit_wr && (&wr_be)) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/pda_par_check.sv
module pda_par_check #(
  parameter int NBYTES = 4,
  localparam int DW = NBYTES * pda_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     rdata,
  input  logic [NBYTES-1:0] rpar,
  input  logic [NBYTES-1:0] rbe,
  input  logic              rvalid,
  output logic [NBYTES-1:0] byte_err,
  output logic              mismatch
);
  import pda_pkg::*;

  logic [NBYTES-1:0] calc_par;

  pda_par_gen #(.NBYTES(NBYTES)) regen_i (
    .data (rdata),
    .par  (calc_par)
  );

  assign byte_err = (calc_par ^ rpar) & rbe & {NBYTES{rvalid}};
  assign mismatch = any_err(16'(byte_err));

  assert_err_only_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> rvalid);
endmodule

// File: rtl/pda_fault.sv
module pda_fault #(
  parameter int FSR_W = 16,
  parameter int PBIT  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mismatch,
  input  logic             fsr_clr,
  output logic [FSR_W-1:0] fsr,
  output logic             abort
);
  logic flag_q;
  logic err_q;
  logic abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      err_q   <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      if (mismatch)     flag_q <= 1'b1;   // set beats clear
      else if (fsr_clr) flag_q <= 1'b0;
      err_q   <= mismatch;
      abort_q <= err_q;
    end
  end

  always_comb begin
    fsr       = '0;
    fsr[PBIT] = flag_q;
  end
  assign abort = abort_q;

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !fsr_clr) |=> flag_q);
  assert_abort_after_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(flag_q));
  assert_abort_follows_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> abort_q);
endmodule

// File: rtl/pda_top.sv
module pda_top #(
  parameter int NBYTES = 4,
  parameter int DEPTH  = 16,
  parameter int FSR_W  = 16,
  parameter int PBIT   = 10,
  localparam int DW    = NBYTES * pda_pkg::BYTE_W,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NBYTES-1:0] wr_be,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NBYTES-1:0] rd_be,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              abort,
  output logic [FSR_W-1:0]  fsr,
  input  logic              fsr_clr,
  input  logic              inj_en,
  input  logic [AW-1:0]     inj_addr,
  input  logic [BW-1:0]     inj_bit
);
  logic [NBYTES-1:0] wr_par;
  logic [DW-1:0]     rdata_q;
  logic [NBYTES-1:0] rpar_q;
  logic [NBYTES-1:0] rbe_q;
  logic              rvalid_q;
  logic [NBYTES-1:0] byte_err;
  logic              mismatch;

  pda_par_gen #(.NBYTES(NBYTES)) wgen_i (
    .data (wr_data),
    .par  (wr_par)
  );

  pda_store #(.NBYTES(NBYTES), .DEPTH(DEPTH)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .wr_par   (wr_par),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_be    (rd_be),
    .inj_en   (inj_en),
    .inj_addr (inj_addr),
    .inj_bit  (inj_bit),
    .rdata_q  (rdata_q),
    .rpar_q   (rpar_q),
    .rbe_q    (rbe_q),
    .rvalid_q (rvalid_q)
  );

  pda_par_check #(.NBYTES(NBYTES)) check_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdata    (rdata_q),
    .rpar     (rpar_q),
    .rbe      (rbe_q),
    .rvalid   (rvalid_q),
    .byte_err (byte_err),
    .mismatch (mismatch)
  );

  pda_fault #(.FSR_W(FSR_W), .PBIT(PBIT)) fault_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mismatch (mismatch),
    .fsr_clr  (fsr_clr),
    .fsr      (fsr),
    .abort    (abort)
  );

  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

  assert_abort_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(rd_valid, 2));
  assert_err_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> ((byte_err & ~rbe_q) == '0));
endmodule

// File: tb/pda_top_tb_top.sv
module pda_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, fsr_clr = 1'b0, inj_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0, inj_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0, rd_be = '0;
  logic [4:0]  inj_bit = '0;
  logic [31:0] rd_data;
  logic        rd_valid, abort;
  logic [15:0] fsr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_mem [16];
  logic [3:0]  m_bad [16];
  bit          m_flag = 0;

  always #(CLK_P/2) clk = ~clk;

  pda_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_be(rd_be), .rd_data(rd_data),
    .rd_valid(rd_valid), .abort(abort), .fsr(fsr), .fsr_clr(fsr_clr),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fsr_exp();
    return m_flag ? 16'h0400 : 16'h0000;
  endfunction

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 0;
    for (int b = 0; b < 4; b++)
      if (be[b]) begin
        m_mem[a][b*8 +: 8] = d[b*8 +: 8];
        m_bad[a][b] = 1'b0;
      end
  endtask

  task automatic inj(logic [3:0] a, logic [4:0] bi);
    @(negedge clk);
    inj_en = 1; inj_addr = a; inj_bit = bi;
    @(negedge clk);
    inj_en = 0;
    m_mem[a][bi] = ~m_mem[a][bi];
    m_bad[a][bi/8] = ~m_bad[a][bi/8];
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [3:0] be);
    bit err;
    err = |(m_bad[a] & be);
    @(negedge clk);
    rd_en = 1; rd_addr = a; rd_be = be;
    @(negedge clk);
    rd_en = 0;
    chk({req, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk({req, " rd_data"}, rd_data, m_mem[a]);
    @(negedge clk);
    if (err) m_flag = 1;
    chk({req, " fsr"}, 32'(fsr), 32'(fsr_exp()));
    chk({req, " abort early"}, 32'(abort), 32'd0);
    @(negedge clk);
    chk({req, " abort"}, 32'(abort), 32'(err));
    @(negedge clk);
    chk({req, " abort width"}, 32'(abort), 32'd0);
  endtask

  task automatic clr_fsr();
    @(negedge clk);
    fsr_clr = 1;
    @(negedge clk);
    fsr_clr = 0;
    m_flag = 0;
    chk("R7 clear", 32'(fsr), 32'd0);
  endtask

  task automatic t_reset();
    chk("R9 rd_valid", 32'(rd_valid), 32'd0);
    chk("R9 abort", 32'(abort), 32'd0);
    chk("R9 fsr", 32'(fsr), 32'd0);
    rd_chk("R9 line0", 4'd0, 4'hF);
    rd_chk("R9 line15", 4'd15, 4'hF);
  endtask

  task automatic t_full_write();
    wr(4'd1, 32'hDEADBEEF, 4'hF);
    wr(4'd2, 32'h00000000, 4'hF);
    wr(4'd3, 32'hFFFFFFFF, 4'hF);
    wr(4'd9, 32'h01020408, 4'hF);
    rd_chk("R1 a", 4'd1, 4'hF);
    rd_chk("R1 b", 4'd2, 4'hF);
    rd_chk("R1 c", 4'd3, 4'hF);
    rd_chk("R1 d", 4'd9, 4'hF);
  endtask

  task automatic t_partial_write();
    wr(4'd4, 32'h11223344, 4'hF);
    wr(4'd4, 32'hAABBCCDD, 4'b0101);
    chk("R2 model", m_mem[4], 32'h11BB33DD);
    rd_chk("R2 merged", 4'd4, 4'hF);
  endtask

  task automatic t_error_abort();
    inj(4'd4, 5'd9);
    rd_chk("R4 R5 R6 err", 4'd4, 4'hF);
    repeat (5) @(negedge clk);
    chk("R7 sticky", 32'(fsr), 32'h400);
    clr_fsr();
    rd_chk("R5 second err", 4'd4, 4'b0010);
    clr_fsr();
  endtask

  task automatic t_mask();
    wr(4'd5, 32'hCAFEF00D, 4'hF);
    inj(4'd5, 5'd30);
    rd_chk("R3 masked", 4'd5, 4'b0111);
    rd_chk("R3 hit", 4'd5, 4'b1000);
    clr_fsr();
    wr(4'd5, 32'h5A000000, 4'b1000);
    rd_chk("R8 repair", 4'd5, 4'hF);
  endtask

  task automatic t_clr_collide();
    wr(4'd6, 32'h00000001, 4'hF);
    inj(4'd6, 5'd0);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'd6; rd_be = 4'hF;
    @(negedge clk);
    rd_en = 0; fsr_clr = 1;
    @(negedge clk);
    fsr_clr = 0;
    m_flag = 1;
    chk("R7 set beats clear", 32'(fsr), 32'h400);
    repeat (2) @(negedge clk);
    clr_fsr();
  endtask

  task automatic t_inj_vs_write();
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd8; wr_data = 32'h13579BDF; wr_be = 4'hF;
    inj_en = 1; inj_addr = 4'd8; inj_bit = 5'd17;
    @(negedge clk);
    wr_en = 0; inj_en = 0;
    m_mem[8] = 32'h13579BDF; m_bad[8] = 4'h0;
    rd_chk("R8 write wins", 4'd8, 4'hF);
  endtask

  task automatic t_rw_same();
    wr(4'd7, 32'h0BADF00D, 4'hF);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'd7; rd_be = 4'hF;
    wr_en = 1; wr_addr = 4'd7; wr_data = 32'h12345678; wr_be = 4'hF;
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    chk("R10 old data", rd_data, 32'h0BADF00D);
    m_mem[7] = 32'h12345678;
    rd_chk("R10 new data", 4'd7, 4'hF);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_mem[i] = '0;
      m_bad[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_write();
    t_partial_write();
    t_error_abort();
    t_mask();
    t_clr_collide();
    t_inj_vs_write();
    t_rw_same();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule